// File: doc/BRIEF.md
# Power-Mode Status and Protection Register Bank

This block is the software-visible register bank of a power controller. It records which low-power state the system most recently came back from, using a stop-exit flag and a standby-exit flag. Hardware event inputs set the flags, and a write-only command bit clears them. The two flags live in different reset domains. A system reset clears the stop-exit flag. Only a power-on reset clears the standby-exit flag, so software can still tell after a system reset that the part came back from standby.

The bank also holds a backup-domain unlock bit. After any reset the backup domain is write-protected. Software must set the unlock bit before writes to backup-domain registers are let through. The block exports a registered copy of this bit, and it gates the backup write strobe with it.

A privilege-lock bit can restrict the whole bank to privileged accesses. Only a privileged access can change the lock bit. An access that is refused returns zero on read and has no effect on write. It raises a one-cycle error pulse.

Accesses use a simple synchronous bus: address, read strobe, write strobe, write data, privilege qualifier and a registered read-data return.

Top module: `pwrmode_regs`

## Requirements
- R1: While `rst_por` is high, and on the first cycle after it falls, the outputs hold these values: `bus_rdata`=0, `acc_err`=0, `bkp_unlock`=0, `bkp_wr_ok`=0. Afterwards, a privileged read of every register returns 0.
- R2: A cycle with `evt_stop_exit` high sets the stop-exit flag from the next cycle. The flag is bit 0 of the status register at word address 1.
- R3: A cycle with `evt_stby_exit` high sets the standby-exit flag from the next cycle. The flag is bit 1 of the status register at word address 1.
- R4: `rst_sys` clears the stop-exit flag and leaves the standby-exit flag unchanged.
- R5: `rst_por` clears both flags, the unlock bit and the lock bit.
- R6: An accepted write with data bit 0 set to word address 0 clears both flags. A write with data bit 0 clear to that address has no effect. A read of word address 0 always returns 0.
- R7: If a set event and the clear command for a flag fall in the same cycle, that flag ends set.
- R8: An accepted write to word address 2 loads data bit 0 into the unlock bit. The unlock bit reads back at bit 0 and drives `bkp_unlock` from the next cycle. `bkp_wr_ok` equals `bkp_wr_req` AND `bkp_unlock`. Either reset clears the unlock bit.
- R9: While the lock bit is 0, unprivileged reads and writes to word addresses 0 to 2 are accepted in the same way as privileged ones.
- R10: While the lock bit is 1, an unprivileged read or write is refused. A refused read returns 0 and a refused write changes nothing. In both cases `acc_err` is high for exactly the next cycle.
- R11: The lock bit is bit 0 of word address 3. It can be read by any accepted read. An unprivileged write to word address 3 is always refused, with the same error pulse as in R10.
- R12: Read data appears on `bus_rdata` one cycle after the read strobe. It is 0 in any cycle that follows no accepted read, and 0 for addresses above 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_sys | input | 1 | System reset, synchronous, active high |
| bus_addr | input | ADDR_W | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | DATA_W | Registered read data |
| acc_err | output | 1 | One-cycle pulse after a refused access |
| evt_stop_exit | input | 1 | Hardware event: system left stop mode |
| evt_stby_exit | input | 1 | Hardware event: system left standby mode |
| bkp_wr_req | input | 1 | Raw write strobe for backup-domain registers |
| bkp_wr_ok | output | 1 | Backup write strobe after protection gating |
| bkp_unlock | output | 1 | Registered backup-domain unlock state |

## Verification
The flags and the lock bit can be seen only through reads, so a wrong flag value shows on `bus_rdata` in the cycle after the next read of address 1. The bench therefore reads the status register often, including straight after a system reset, where the standby-exit flag must survive.

A wrong lock or unlock state shows at once on `acc_err` or `bkp_wr_ok`: one cycle after the next unprivileged access, or in the same cycle as the next backup write request. The bench compares every cycle against a reference model, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned NUM_FLAGS = 2;

  typedef enum logic [SEL_W-1:0] {
    REG_CMD  = 2'd0,
    REG_STAT = 2'd1,
    REG_BKP  = 2'd2,
    REG_PRIV = 2'd3
  } reg_sel_e;

  // flag index equals its bit position in the status word
  localparam int unsigned FLAG_STOP = 0;
  localparam int unsigned FLAG_STBY = 1;
  // flags that a system reset also clears
  localparam logic [NUM_FLAGS-1:0] SYS_RST_CLEARS = 2'b01;
endpackage

// File: rtl/pwrmode_access.sv
module pwrmode_access
  import pwrmode_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic                 bus_priv,
  input  logic                 lock_q,
  output logic [NUM_REGS-1:0]  wr_stb,
  output logic                 rd_ok,
  output reg_sel_e             sel,
  output logic                 err_q
);
  localparam int unsigned HI_W = ADDR_W - SEL_W;

  logic mapped, allowed, priv_wr_denied, blocked, wr_ok;

  assign sel            = reg_sel_e'(bus_addr[SEL_W-1:0]);
  assign mapped         = (bus_addr[ADDR_W-1:SEL_W] == HI_W'(0));
  assign allowed        = bus_priv | ~lock_q;
  assign priv_wr_denied = bus_wr & ~bus_priv & mapped & (sel == REG_PRIV);
  assign blocked        = ~rst & ((((bus_wr | bus_rd) & ~allowed)) | priv_wr_denied);
  assign wr_ok          = ~rst & bus_wr & allowed & ~priv_wr_denied & mapped;
  assign rd_ok          = ~rst & bus_rd & allowed & mapped;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_stb
    assign wr_stb[i] = wr_ok & (sel == reg_sel_e'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= blocked;
  end
endmodule

// File: rtl/pwrmode_flags.sv
module pwrmode_flags
  import pwrmode_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_por,
  input  logic                  rst_sys,
  input  logic [NUM_FLAGS-1:0]  set_ev,
  input  logic                  clr_cmd,
  output logic [NUM_FLAGS-1:0]  flag_q
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic rst_i;
    if (SYS_RST_CLEARS[i]) begin : g_sys
      assign rst_i = rst_por | rst_sys;
    end else begin : g_por
      assign rst_i = rst_por;
    end
    always_ff @(posedge clk) begin
      if (rst_i)          flag_q[i] <= 1'b0;
      else if (set_ev[i]) flag_q[i] <= 1'b1;
      else if (clr_cmd)   flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrmode_regs.sv
module pwrmode_regs
  import pwrmode_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_sys,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              acc_err,
  input  logic              evt_stop_exit,
  input  logic              evt_stby_exit,
  input  logic              bkp_wr_req,
  output logic              bkp_wr_ok,
  output logic              bkp_unlock
);
  logic                 rst_any;
  logic [NUM_REGS-1:0]  wr_stb;
  logic                 rd_ok;
  reg_sel_e             sel;
  logic                 lock_q;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 stop_q, stby_q;
  logic [DATA_W-1:0]    rd_mux;

  assign rst_any = rst_por | rst_sys;

  pwrmode_access #(.ADDR_W(ADDR_W)) u_access (
    .clk      (clk),
    .rst      (rst_any),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_priv (bus_priv),
    .lock_q   (lock_q),
    .wr_stb   (wr_stb),
    .rd_ok    (rd_ok),
    .sel      (sel),
    .err_q    (acc_err)
  );

  pwrmode_flags u_flags (
    .clk     (clk),
    .rst_por (rst_por),
    .rst_sys (rst_sys),
    .set_ev  ({evt_stby_exit, evt_stop_exit}),
    .clr_cmd (wr_stb[REG_CMD] & bus_wdata[0]),
    .flag_q  (flag_q)
  );

  assign stop_q = flag_q[FLAG_STOP];
  assign stby_q = flag_q[FLAG_STBY];

  always_ff @(posedge clk) begin
    if (rst_any) begin
      bkp_unlock <= 1'b0;
      lock_q     <= 1'b0;
    end else begin
      if (wr_stb[REG_BKP])  bkp_unlock <= bus_wdata[0];
      if (wr_stb[REG_PRIV]) lock_q     <= bus_wdata[0];
    end
  end

  assign bkp_wr_ok = bkp_wr_req & bkp_unlock;

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_STAT: rd_mux[NUM_FLAGS-1:0] = flag_q;
      REG_BKP:  rd_mux[0] = bkp_unlock;
      REG_PRIV: rd_mux[0] = lock_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any)    bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end
endmodule

// File: rtl/pwrmode_regs_chk.sv
module pwrmode_regs_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_por,
  input logic              rst_sys,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_priv,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              acc_err,
  input logic              evt_stop_exit,
  input logic              evt_stby_exit,
  input logic              bkp_unlock,
  input logic              stop_q,
  input logic              stby_q,
  input logic              lock_q
);
  AST_STOP_SET: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    evt_stop_exit |=> stop_q); // R2
  AST_STBY_SET: assert property (@(posedge clk) disable iff (rst_por)
    evt_stby_exit |=> stby_q); // R3
  AST_STBY_KEEP_SYS: assert property (@(posedge clk) disable iff (rst_por)
    (rst_sys && stby_q) |=> stby_q); // R4
  AST_STOP_CLR_SYS: assert property (@(posedge clk) disable iff (rst_por)
    rst_sys |=> !stop_q); // R4
  AST_POR_CLEARS: assert property (@(posedge clk)
    rst_por |=> (!stop_q && !stby_q && !bkp_unlock && !lock_q)); // R5
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (bus_rd && bus_addr == ADDR_W'(0)) |=> (bus_rdata == '0)); // R6
  AST_UNLOCK_BY_WRITE: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    $rose(bkp_unlock) |-> $past(bus_wr)); // R8
  AST_LOCKED_ERR: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    (lock_q && !bus_priv && (bus_wr || bus_rd)) |=> acc_err); // R10
  AST_LOCK_PRIV_ONLY: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    !bus_priv |=> $stable(lock_q)); // R11
endmodule

bind pwrmode_regs pwrmode_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_por       (rst_por),
  .rst_sys       (rst_sys),
  .bus_addr      (bus_addr),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_priv      (bus_priv),
  .bus_rdata     (bus_rdata),
  .acc_err       (acc_err),
  .evt_stop_exit (evt_stop_exit),
  .evt_stby_exit (evt_stby_exit),
  .bkp_unlock    (bkp_unlock),
  .stop_q        (stop_q),
  .stby_q        (stby_q),
  .lock_q        (lock_q)
);

// File: tb/pwrmode_regs_tb.sv
module pwrmode_regs_tb;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  logic clk = 1'b0;
  logic rst_por = 1'b1, rst_sys = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic acc_err, bkp_wr_ok, bkp_unlock;
  logic evt_stop_exit = 1'b0, evt_stby_exit = 1'b0, bkp_wr_req = 1'b0;

  int n_tests = 0, n_fail = 0;

  // reference model
  logic m_stop = 0, m_stby = 0, m_unlock = 0, m_lock = 0;

  always #5 clk = ~clk;

  pwrmode_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .acc_err(acc_err), .evt_stop_exit(evt_stop_exit), .evt_stby_exit(evt_stby_exit),
    .bkp_wr_req(bkp_wr_req), .bkp_wr_ok(bkp_wr_ok), .bkp_unlock(bkp_unlock)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    case (a)
      4'd1:    return DATA_W'({m_stby, m_stop});
      4'd2:    return DATA_W'(m_unlock);
      4'd3:    return DATA_W'(m_lock);
      default: return '0;
    endcase
  endfunction

  // one bus cycle; checks registered outputs one cycle later
  task automatic step(input logic wr, input logic rd, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic priv,
                      input logic es, input logic eb, input logic req, input string tag);
    logic allowed, denied, blocked, wr_ok, clr;
    logic [DATA_W-1:0] e_rd;
    allowed = priv || !m_lock;
    denied  = wr && !priv && (a == 4'd3);
    blocked = ((wr || rd) && !allowed) || denied;
    wr_ok   = wr && allowed && !denied;
    e_rd    = (rd && allowed) ? exp_read(a) : '0;
    clr     = wr_ok && (a == 4'd0) && d[0];
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; bus_priv = priv;
    evt_stop_exit = es; evt_stby_exit = eb; bkp_wr_req = req;
    #1;
    chk("R8 gate", DATA_W'(bkp_wr_ok), DATA_W'(req && m_unlock));
    @(posedge clk); #1;
    m_stop = es ? 1'b1 : (clr ? 1'b0 : m_stop);
    m_stby = eb ? 1'b1 : (clr ? 1'b0 : m_stby);
    if (wr_ok && a == 4'd2) m_unlock = d[0];
    if (wr_ok && a == 4'd3) m_lock = d[0];
    bus_wr = 0; bus_rd = 0; evt_stop_exit = 0; evt_stby_exit = 0; bkp_wr_req = 0;
    chk({tag, " R12 rdata"}, bus_rdata, e_rd);
    chk({tag, " R10 err"}, DATA_W'(acc_err), DATA_W'(blocked));
    chk("R8 unlock", DATA_W'(bkp_unlock), DATA_W'(m_unlock));
  endtask

  task automatic do_reset(input logic por, input logic sys);
    rst_por = por; rst_sys = sys;
    bus_wr = 0; bus_rd = 0; evt_stop_exit = 0; evt_stby_exit = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 rdata", bus_rdata, '0);
    chk("R1 err", DATA_W'(acc_err), '0);
    rst_por = 0; rst_sys = 0;
    m_stop = 0; m_unlock = 0; m_lock = 0;
    if (por) m_stby = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    do_reset(1, 0);
    chk("R1 unlock", DATA_W'(bkp_unlock), '0);
    chk("R1 wr_ok", DATA_W'(bkp_wr_ok), '0);
    for (int a = 0; a < 4; a++) step(0, 1, a[3:0], 0, 1, 0, 0, 1, "R1 read");

    // stop and standby events
    step(0, 0, 0, 0, 1, 1, 0, 0, "R2 set");
    step(0, 1, 1, 0, 1, 0, 0, 0, "R2 read");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R3 set");
    step(0, 1, 1, 0, 1, 0, 0, 0, "R3 read");
    // system reset keeps standby
    do_reset(0, 1);
    step(0, 1, 1, 0, 1, 0, 0, 0, "R4 read");
    chk("R4 stby kept", bus_rdata, 32'h2);
    // power-on reset clears all
    step(0, 0, 0, 0, 1, 1, 0, 0, "R5 set");
    do_reset(1, 0);
    step(0, 1, 1, 0, 1, 0, 0, 0, "R5 read");
    chk("R5 cleared", bus_rdata, 32'h0);
    // clear command
    step(0, 0, 0, 0, 1, 1, 1, 0, "R6 set");
    step(1, 0, 0, 32'hFFFF_FFFE, 1, 0, 0, 0, "R6 wr0");
    step(0, 1, 1, 0, 1, 0, 0, 0, "R6 held");
    step(1, 1, 0, 32'h1, 0, 0, 0, 0, "R6 clr");
    chk("R6 cmd reads 0", bus_rdata, 32'h0);
    step(0, 1, 1, 0, 1, 0, 0, 0, "R6 read");
    chk("R6 cleared", bus_rdata, 32'h0);
    // set wins
    step(1, 0, 0, 32'h1, 1, 1, 0, 0, "R7 race");
    step(0, 1, 1, 0, 1, 0, 0, 0, "R7 read");
    chk("R7 stop kept", bus_rdata, 32'h1);
    // unlock by unprivileged access when not locked
    step(1, 0, 2, 32'h1, 0, 0, 0, 1, "R9 unlock");
    step(0, 1, 2, 0, 0, 0, 0, 1, "R9 read");
    chk("R8 readback", bus_rdata, 32'h1);
    // unprivileged lock write refused
    step(1, 0, 3, 32'h1, 0, 0, 0, 0, "R11 deny");
    chk("R11 err", DATA_W'(acc_err), 32'h1);
    step(1, 0, 3, 32'h1, 1, 0, 0, 0, "R11 lock");
    step(0, 1, 3, 0, 0, 0, 0, 0, "R10 rd blocked");
    chk("R10 rd zero", bus_rdata, 32'h0);
    step(1, 0, 2, 32'h0, 0, 0, 0, 1, "R10 wr blocked");
    chk("R10 unlock kept", DATA_W'(bkp_unlock), 32'h1);
    step(0, 0, 0, 0, 1, 0, 0, 0, "R10 idle");
    chk("R10 single pulse", DATA_W'(acc_err), 32'h0);
    step(0, 1, 4'hB, 0, 1, 0, 0, 0, "R12 unmapped");
    chk("R12 unmapped zero", bus_rdata, 32'h0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:26] == 0) do_reset(r[25], !r[25]);
      else step(r[0], r[1], (r[2] ? r[6:3] : {2'b00, r[4:3]}), {r[24:8], r[7]},
                r[9] | r[10], r[11] & r[12], r[13] & r[14], r[15], "R9 rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule